// File: doc/BRIEF.md
# Trigger-Aligned Running Template Canceller

This block removes a repeating disturbance from a stream of signed samples when the disturbance always follows an external event. A trigger marks the start of each occurrence. The block cuts a window of a fixed number of samples from that point. At every offset inside the window it keeps the mean of the same offset over the most recent windows. Each new sample inside a window leaves the block with that mean subtracted.

Outside a window the samples pass through untouched. The mean is a running one: every finished window pushes out the oldest stored window, so slow changes in the disturbance's shape are followed. Until enough windows have been collected for a full mean, the block passes every sample unchanged and holds its ready flag low. Output samples appear one clock after the input sample they belong to.

Top module: `trig_template_avg`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `tmpl_ready` and `out_data` are all 0.
- R2: Every clock edge with `in_valid` high yields `out_valid` high after that edge, carrying the result for that sample. An edge with `in_valid` low yields `out_valid` low and changes no state. A trigger seen without `in_valid` has no effect.
- R3: A valid sample with `trig` high, arriving while no window is open, is offset 0 of a new window. The window then spans exactly SEG_LEN consecutive valid samples, at offsets 0 to SEG_LEN-1. The next valid sample after the last offset is outside any window unless it carries a trigger.
- R4: A trigger on a valid sample inside an open window is ignored. That sample keeps its running offset, and the window ends at its normal place.
- R5: A valid sample outside any window appears unchanged on `out_data`.
- R6: `tmpl_ready` goes high on the edge that accepts the last sample of the NAVG-th window since reset, and then stays high until reset.
- R7: While `tmpl_ready` is low, samples inside windows also appear unchanged on `out_data`.
- R8: While `tmpl_ready` is high, a sample x at window offset n gives x - T(n). T(n) = (S(n)*RCP + 2^(FRAC-1)) >> FRAC, an arithmetic shift. S(n) is the sum of the samples at offset n over the NAVG most recently finished windows. RCP = floor((2^FRAC + floor(NAVG/2)) / NAVG). The defaults are FRAC=24, NAVG=20 and SEG_LEN=128.
- R9: The mean is running: each finished window replaces the oldest stored one. After NAVG windows of a changed waveform, the template equals the mean of the new waveform alone.
- R10: The difference x - T(n) saturates to the signed 16-bit range, -32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DW | Input sample, signed two's complement |
| trig | input | 1 | Window start marker, qualified by in_valid |
| out_valid | output | 1 | Output sample valid, one clock after input |
| out_data | output | DW | Cancelled or passed-through sample, signed |
| tmpl_ready | output | 1 | Template holds a full NAVG-window mean |

## Verification
On every cycle, the assertions check the one-clock validity timing and that the ready flag never drops. They also check the pass-through of samples before the ready flag and outside windows, how a window opens, and that a trigger inside an open window is ignored.

Some behaviour only the directed scenarios can show. This covers the exact rounded template value at every offset and the point where the ready flag rises. It also covers how the template follows a changed waveform after NAVG windows, and saturation at both ends of the range. For these, the bench keeps its own record of past windows and recomputes each mean from scratch.

// File: rtl/trig_template_avg.sv
module trig_template_avg #(
  parameter int DW      = 16,
  parameter int SEG_LEN = 128,
  parameter int NAVG    = 20,
  parameter int FRAC    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          trig,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          tmpl_ready
);
  localparam int OW  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam int CW  = $clog2(NAVG + 1);
  localparam int SLW = (NAVG > 1) ? $clog2(NAVG) : 1;
  localparam int HD  = NAVG * SEG_LEN;
  localparam int HW  = (HD > 1) ? $clog2(HD) : 1;
  localparam int SW  = DW + SLW + 1;
  localparam int PW  = SW + FRAC + 2;
  localparam logic [63:0] RCP64 = ((64'd1 << FRAC) + 64'(NAVG / 2)) / 64'(NAVG);
  localparam logic signed [PW-1:0] RCP  = PW'(RCP64);
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic           active;
  logic [OW-1:0]  off;
  logic [CW-1:0]  nseg;
  logic [SLW-1:0] slot;
  logic [DW-1:0]  hist [HD];
  logic signed [SW-1:0] sums [SEG_LEN];

  wire start  = in_valid & trig & ~active;
  wire inseg  = in_valid & (active | start);
  wire full   = (nseg == CW'(NAVG));
  wire first  = (nseg == '0);
  wire [OW-1:0] cur_off = active ? off : '0;
  wire last   = (cur_off == OW'(SEG_LEN - 1));
  wire [HW-1:0] haddr = HW'(slot) * HW'(SEG_LEN) + HW'(cur_off);

  logic [DW-1:0]        hold;
  logic signed [SW-1:0] x_sw, old_sw, sum_rd, sum_nx;
  logic signed [PW-1:0] x_pw, sum_pw, prod, tmpl, diff;
  logic [DW-1:0]        sat, result;

  always_comb begin
    hold   = hist[haddr];
    x_sw   = {{(SW-DW){in_data[DW-1]}}, in_data};
    old_sw = full ? {{(SW-DW){hold[DW-1]}}, hold} : '0;
    sum_rd = first ? '0 : sums[cur_off];
    sum_nx = sum_rd + x_sw - old_sw;
    sum_pw = {{(PW-SW){sum_rd[SW-1]}}, sum_rd};
    x_pw   = {{(PW-DW){in_data[DW-1]}}, in_data};
    prod   = sum_pw * RCP;
    tmpl   = (prod + HALF) >>> FRAC;
    diff   = x_pw - tmpl;
    if (diff > MAXV)      sat = MAXV[DW-1:0];
    else if (diff < MINV) sat = MINV[DW-1:0];
    else                  sat = diff[DW-1:0];
    result = (inseg & full) ? sat : in_data;
  end

  always_ff @(posedge clk) begin
    if (inseg) begin
      hist[haddr]   <= in_data;
      sums[cur_off] <= sum_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      off       <= '0;
      nseg      <= '0;
      slot      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
      if (inseg) begin
        if (last) begin
          active <= 1'b0;
          off    <= '0;
          slot   <= (slot == SLW'(NAVG - 1)) ? '0 : slot + SLW'(1);
          if (!full) nseg <= nseg + CW'(1);
        end else begin
          active <= 1'b1;
          off    <= cur_off + OW'(1);
        end
      end
    end
  end

  assign tmpl_ready = full;
endmodule

// File: rtl/trig_template_avg_checker.sv
module trig_template_avg_checker #(
  parameter int DW      = 16,
  parameter int SEG_LEN = 128,
  parameter int OW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          trig,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          tmpl_ready,
  input logic          seg_active,
  input logic [OW-1:0] seg_off
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmpl_ready |=> tmpl_ready);
  a_r6_ready_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmpl_ready) |-> $past(in_valid));
  a_r7_pass_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tmpl_ready) |=> (out_data == $past(in_data)));
  a_r5_pass_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trig && !seg_active) |=> (out_data == $past(in_data)));
  a_r3_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && trig && !seg_active && SEG_LEN > 1) |=> (seg_active && seg_off == OW'(1)));
  a_r4_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && trig && seg_active && seg_off != OW'(SEG_LEN - 1))
      |=> (seg_active && seg_off == $past(seg_off) + OW'(1)));
endmodule

bind trig_template_avg trig_template_avg_checker #(
  .DW(DW), .SEG_LEN(SEG_LEN), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .trig(trig),
  .out_valid(out_valid), .out_data(out_data), .tmpl_ready(tmpl_ready),
  .seg_active(active), .seg_off(off)
);

// File: tb/trig_template_avg_test.sv
module trig_template_avg_test;
  localparam int CLK_NS = 10;
  localparam int DW = 16, L = 128, K = 20, FRAC = 24;

  logic clk = 0, rst_n = 0, in_valid = 0, trig = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, tmpl_ready;
  logic [DW-1:0] out_data;

  trig_template_avg #(.DW(DW), .SEG_LEN(L), .NAVG(K), .FRAC(FRAC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .trig(trig),
    .out_valid(out_valid), .out_data(out_data), .tmpl_ready(tmpl_ready));

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0;
  int mh [K][L];
  int m_cnt = 0, m_slot = 0, m_off = 0;
  bit m_act = 0;
  longint recip = ((64'sd1 <<< FRAC) + K/2) / K;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tmpl(int o);
    longint s = 0;
    for (int j = 0; j < K; j++) s += mh[j][o];
    return int'((s * recip + (64'sd1 <<< (FRAC-1))) >>> FRAC);
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic send(int x, bit tg, string tag);
    bit st, ins, full;
    int o, exp;
    @(negedge clk);
    in_valid = 1; trig = tg; in_data = x[DW-1:0];
    st = tg && !m_act; ins = m_act || st; o = m_act ? m_off : 0; full = (m_cnt == K);
    exp = (ins && full) ? sat16(x - exp_tmpl(o)) : x;
    if (ins) begin
      mh[m_slot][o] = x;
      if (o == L-1) begin
        m_act = 0; m_off = 0; m_slot = (m_slot + 1) % K;
        if (m_cnt < K) m_cnt++;
      end else begin
        m_act = 1; m_off = o + 1;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; trig = 0;
    check(out_valid == 1'b1, "R2", int'(out_valid), 1);
    check(int'($signed(out_data)) == exp, tag, int'($signed(out_data)), exp);
    check(tmpl_ready == (m_cnt == K), "R6", int'(tmpl_ready), int'(m_cnt == K));
  endtask

  task automatic idle(bit tg);
    @(negedge clk);
    in_valid = 0; trig = tg; in_data = 16'h5a5a;
    @(posedge clk); #1;
    trig = 0;
    check(out_valid == 1'b0, "R2", int'(out_valid), 0);
  endtask

  function automatic int wave(int base, int step, int s, int o);
    return base + step * o + ((s * 13 + o * 7) % 9) - 4;
  endfunction

  task automatic window(int base, int step, int s, string tag, int trig_at);
    for (int o = 0; o < L; o++)
      send(wave(base, step, s, o), (o == 0) || (o == trig_at), (o == trig_at) ? "R4" : tag);
    send(1234 + s, 0, "R3");
    send(-77, 0, "R5");
  endtask

  task automatic t_reset;
    rst_n = 0; in_valid = 1; trig = 1; in_data = 16'h7fff;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0, "R1", int'(out_valid), 0);
    check(tmpl_ready == 0, "R1", int'(tmpl_ready), 0);
    check(out_data == 0, "R1", int'(out_data), 0);
    @(negedge clk); in_valid = 0; trig = 0; rst_n = 1;
  endtask

  task automatic t_passthrough;
    send(32767, 0, "R5"); send(-32768, 0, "R5"); send(0, 0, "R5"); send(-1, 0, "R5");
    idle(1); idle(0);
    send(555, 0, "R2");
  endtask

  task automatic t_fill;
    for (int s = 0; s < K; s++) begin
      window(-2000, 20, s, "R7", (s == 3) ? 40 : -1);
      if (s == 5) idle(1);
    end
  endtask

  task automatic t_cancel;
    for (int s = K; s < K + 3; s++) window(-2000, 20, s, "R8", (s == K + 1) ? 100 : -1);
  endtask

  task automatic t_drift;
    for (int s = 0; s < K + 5; s++) window(1500, -9, s + 50, "R9", -1);
  endtask

  task automatic t_sat;
    for (int s = 0; s < K; s++) window(-30000, 0, 0, "R8", -1);
    window(30000, 0, 0, "R10", -1);
    for (int s = 0; s < K; s++) window(30000, 0, 0, "R8", -1);
    window(-30000, 0, 0, "R10", -1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_fill();
    t_cancel();
    t_drift();
    t_sat();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule